// File: doc/BRIEF.md
# Interrupt-Capable General-Purpose Pin Controller

This block controls 32 general-purpose pins through a small memory-mapped register bus. The bus has a byte address, a write strobe, write data and combinational read data. Each pin is set up on its own as a plain input, a driven output, or an interrupt source. An interrupt source can watch for a high level, a low level, a rising edge or a falling edge. Pending interrupts are latched per pin, masked per pin and cleared per pin, and all pins share one registered interrupt line.

Pad inputs pass through a two-stage synchroniser before software can read them or the sense logic can use them. The output value register keeps its contents while a pin is an input. Software can therefore load the level it wants before switching a pin to output, and the pin drives that level from the first cycle.

An interrupt handler reads the pending word and clears the lowest set bit by writing a one to that bit of the clear register. It repeats this until the pending word reads zero.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, every readable register reads 0 except the mask register at offset 0x18, which reads 0xFFFFFFFF (all pins masked). After reset `irq` is 0 and `pad_oe` is 0.
- R2: `pad_oe[i]` is 1 only when mode bit i (offset 0x00) is 0 and direction bit i (offset 0x04) is 1. `pad_out` always equals the output value register (offset 0x08), including while the pin is an input.
- R3: The input data word (offset 0x0C) reflects `pad_in` two clock edges after the pads change, and still holds the old value after one edge.
- R4: A pin with mode bit 1 and sense-type bit 0 (offset 0x24) is level-sensed. Its pending bit (offset 0x10) equals the synchronised pad XOR its polarity bit (offset 0x20; 0 means active high, 1 means active low). It is due three edges after the pad change.
- R5: A pin with mode bit 1 and sense-type bit 1 is edge-sensed. A rising edge (polarity 0) or a falling edge (polarity 1) sets its pending bit three edges after the pad change, and the bit stays set until it is cleared.
- R6: Writing 1 to a bit of the clear register (offset 0x14) clears that edge-sensed pending bit. Writing 0 has no effect. Clearing the lowest set bit repeatedly drains the pending word to zero.
- R7: Writing 1 to a bit at offset 0x18 masks that pin, and writing 1 at offset 0x1C unmasks it. Bits written 0 leave the mask unchanged in both cases.
- R8: `irq` is the OR of pending bits that are not masked. It is registered and follows a pending or mask change by one clock edge.
- R9: A pin with mode bit 0 never shows a pending bit, whatever its pad, polarity or sense type.
- R10: The mode, direction, output, polarity, sense-type and filter-enable (offset 0x28) registers read back the last value written. Offsets 0x14 and 0x1C read 0. A write whose address has nonzero low two bits is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | Byte address of the register |
| bus_we | input | 1 | Write strobe, sampled on the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| pad_in | input | 32 | Asynchronous pad input levels |
| pad_out | output | 32 | Value driven on the pads |
| pad_oe | output | 32 | Per-pin output enable |
| irq | output | 1 | Combined interrupt request |

## Verification
A register write takes effect at the edge that samples it and is visible on a read half a cycle later. The synchronised input is due two edges after a pad change, pending bits three edges after, and `irq` one edge after the pending or mask change that causes it. The bench drives every input at a falling edge and reads at the falling edge after the due rising edge. It also samples one edge early for the input word and for `irq`, to confirm that neither result arrives ahead of time. Pad steps are held for four edges before pending is compared with a model built from the requirements.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int NPIN   = 32;
    localparam int ADDR_W = 6;
    localparam int SEL_W  = ADDR_W - 2;

    typedef enum logic [SEL_W-1:0] {
        RG_MODE = 4'h0,
        RG_DIR  = 4'h1,
        RG_OUT  = 4'h2,
        RG_IN   = 4'h3,
        RG_PEND = 4'h4,
        RG_CLR  = 4'h5,
        RG_MSET = 4'h6,
        RG_MCLR = 4'h7,
        RG_POL  = 4'h8,
        RG_SENS = 4'h9,
        RG_FILT = 4'hA,
        RG_NONE = 4'hF
    } reg_sel_e;

    typedef struct packed {
        logic [NPIN-1:0] mode;
        logic [NPIN-1:0] dir;
        logic [NPIN-1:0] dout;
        logic [NPIN-1:0] pol;
        logic [NPIN-1:0] sens;
        logic [NPIN-1:0] filt;
        logic [NPIN-1:0] mask;
    } cfg_t;

    // Word-aligned addresses select a register; misaligned ones select nothing.
    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        if (a[1:0] != 2'b00) return RG_NONE;
        return reg_sel_e'(a[ADDR_W-1:2]);
    endfunction

endpackage

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  reg_sel_e        sel,
    input  logic [NPIN-1:0] wdata,
    output cfg_t            cfg,
    output logic [NPIN-1:0] clr_pulse
);

    cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q      <= '0;
            cfg_q.mask <= '1;
        end else if (we) begin
            case (sel)
                RG_MODE: cfg_q.mode <= wdata;
                RG_DIR:  cfg_q.dir  <= wdata;
                RG_OUT:  cfg_q.dout <= wdata;
                RG_POL:  cfg_q.pol  <= wdata;
                RG_SENS: cfg_q.sens <= wdata;
                RG_FILT: cfg_q.filt <= wdata;
                RG_MSET: cfg_q.mask <= cfg_q.mask | wdata;
                RG_MCLR: cfg_q.mask <= cfg_q.mask & ~wdata;
                default: ;
            endcase
        end
    end

    assign cfg       = cfg_q;
    assign clr_pulse = (we && sel == RG_CLR) ? wdata : '0;

    // R7: bits written 1 to the set port are masked on the next cycle
    p_mask_set_r7: assert property (@(posedge clk) disable iff (rst)
        (we && sel == RG_MSET) |=> ((cfg.mask & $past(wdata)) == $past(wdata)));

    // R7: bits written 1 to the clear port are unmasked on the next cycle
    p_mask_clr_r7: assert property (@(posedge clk) disable iff (rst)
        (we && sel == RG_MCLR) |=> ((cfg.mask & $past(wdata)) == '0));

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync
    import gpio_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NPIN-1:0] pad_in,
    output logic [NPIN-1:0] in_sync,
    output logic [NPIN-1:0] in_prev
);

    logic [NPIN-1:0] stage1, stage2, stage3;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            stage2 <= '0;
            stage3 <= '0;
        end else begin
            stage1 <= pad_in;
            stage2 <= stage1;
            stage3 <= stage2;
        end
    end

    assign in_sync = stage2;
    assign in_prev = stage3;

    // Checker-only age counter so the two-cycle look-back starts after reset.
    logic [1:0] warm;
    always_ff @(posedge clk) begin
        if (rst)            warm <= 2'd0;
        else if (warm != 2) warm <= warm + 2'd1;
    end

    // R3: synchronised value is the pad as sampled two edges earlier
    p_two_stage_r3: assert property (@(posedge clk) disable iff (rst)
        (warm == 2'd2) |-> (in_sync == $past(pad_in, 2)));

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
    import gpio_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NPIN-1:0] mode,
    input  logic [NPIN-1:0] pol,
    input  logic [NPIN-1:0] sens,
    input  logic [NPIN-1:0] in_sync,
    input  logic [NPIN-1:0] in_prev,
    input  logic [NPIN-1:0] clr,
    output logic [NPIN-1:0] pend
);

    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        logic active_now, active_was, hit;

        assign active_now = in_sync[i] ^ pol[i];
        assign active_was = in_prev[i] ^ pol[i];
        assign hit        = active_now & ~active_was;

        always_ff @(posedge clk) begin
            if (rst || !mode[i])  pend[i] <= 1'b0;
            else if (sens[i])     pend[i] <= hit | (pend[i] & ~clr[i]);
            else                  pend[i] <= active_now;
        end
    end

    // R9: a pin in general mode holds no pending bit
    p_gen_idle_r9: assert property (@(posedge clk) disable iff (rst)
        ((pend & ~$past(mode)) == '0));

    // R5: an edge-sensed pending bit is never lost without a clear
    p_edge_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        ((~pend & $past(pend & mode & sens & ~clr)) == '0));

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [NPIN-1:0]   bus_wdata,
    output logic [NPIN-1:0]   bus_rdata,
    input  logic [NPIN-1:0]   pad_in,
    output logic [NPIN-1:0]   pad_out,
    output logic [NPIN-1:0]   pad_oe,
    output logic              irq
);

    reg_sel_e        sel;
    cfg_t            cfg;
    logic [NPIN-1:0] clr_pulse;
    logic [NPIN-1:0] in_sync, in_prev;
    logic [NPIN-1:0] pend;

    assign sel = decode_addr(bus_addr);

    gpio_regfile u_regs (
        .clk       (clk),
        .rst       (rst),
        .we        (bus_we),
        .sel       (sel),
        .wdata     (bus_wdata),
        .cfg       (cfg),
        .clr_pulse (clr_pulse)
    );

    gpio_in_sync u_sync (
        .clk     (clk),
        .rst     (rst),
        .pad_in  (pad_in),
        .in_sync (in_sync),
        .in_prev (in_prev)
    );

    gpio_irq_detect u_detect (
        .clk     (clk),
        .rst     (rst),
        .mode    (cfg.mode),
        .pol     (cfg.pol),
        .sens    (cfg.sens),
        .in_sync (in_sync),
        .in_prev (in_prev),
        .clr     (clr_pulse),
        .pend    (pend)
    );

    always_comb begin
        case (sel)
            RG_MODE: bus_rdata = cfg.mode;
            RG_DIR:  bus_rdata = cfg.dir;
            RG_OUT:  bus_rdata = cfg.dout;
            RG_IN:   bus_rdata = in_sync;
            RG_PEND: bus_rdata = pend;
            RG_MSET: bus_rdata = cfg.mask;
            RG_POL:  bus_rdata = cfg.pol;
            RG_SENS: bus_rdata = cfg.sens;
            RG_FILT: bus_rdata = cfg.filt;
            default: bus_rdata = '0;
        endcase
    end

    assign pad_out = cfg.dout;
    assign pad_oe  = cfg.dir & ~cfg.mode;

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= |(pend & ~cfg.mask);
    end

    // R8: with every pin masked the request line stays low
    p_masked_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (&$past(cfg.mask)) |-> !irq);

endmodule

// File: tb/test_gpio_irq_ctrl.sv
`timescale 1ns/1ps
module test_gpio_irq_ctrl;

    localparam logic [5:0] A_MODE = 6'h00, A_DIR = 6'h04, A_OUT = 6'h08,
                           A_IN = 6'h0C, A_PEND = 6'h10, A_CLR = 6'h14,
                           A_MSET = 6'h18, A_MCLR = 6'h1C, A_POL = 6'h20,
                           A_SENS = 6'h24, A_FILT = 6'h28;

    logic        clk = 0, rst = 1;
    logic [5:0]  bus_addr = '0;
    logic        bus_we = 0;
    logic [31:0] bus_wdata = '0, bus_rdata, pad_in = '0, pad_out, pad_oe;
    logic        irq;

    int checks = 0, failures = 0;
    bit done = 0;

    always #2 clk = ~clk;

    gpio_irq_ctrl i_gpio_irq_ctrl (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1; bus_wdata = d;
        @(posedge clk); #1;
        bus_we = 0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; #1;
        d = bus_rdata;
    endtask

    task automatic set_pad(input logic [31:0] v);
        @(negedge clk);
        pad_in = v;
    endtask

    logic [31:0] v, pol_m, sens_m, pend_m, lvl_prev, lvl;
    logic [31:0] steps [6];

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;

        // R1 reset state
        rd(A_MODE, v); check("R1 mode", v, 0);
        rd(A_DIR, v);  check("R1 dir", v, 0);
        rd(A_OUT, v);  check("R1 out", v, 0);
        rd(A_IN, v);   check("R1 in", v, 0);
        rd(A_PEND, v); check("R1 pend", v, 0);
        rd(A_POL, v);  check("R1 pol", v, 0);
        rd(A_SENS, v); check("R1 sens", v, 0);
        rd(A_FILT, v); check("R1 filt", v, 0);
        rd(A_MSET, v); check("R1 mask", v, 32'hFFFF_FFFF);
        check("R1 irq", {31'b0, irq}, 0);
        check("R1 oe", pad_oe, 0);

        // R10 readback, write-only offsets, misaligned write
        wr(A_POL, 32'hA5A5_5A5A);  rd(A_POL, v);  check("R10 pol", v, 32'hA5A5_5A5A);
        wr(A_FILT, 32'h1234_5678); rd(A_FILT, v); check("R10 filt", v, 32'h1234_5678);
        wr(A_SENS, 32'h0F0F_00FF); rd(A_SENS, v); check("R10 sens", v, 32'h0F0F_00FF);
        rd(A_CLR, v);  check("R10 clr reads zero", v, 0);
        rd(A_MCLR, v); check("R10 mclr reads zero", v, 0);
        wr(6'h05, 32'hDEAD_BEEF);  rd(A_DIR, v);  check("R10 misaligned dir", v, 0);
        rd(A_OUT, v);  check("R10 misaligned out", v, 0);
        wr(A_POL, 0); wr(A_FILT, 0); wr(A_SENS, 0);

        // R2 output retention and enable
        wr(A_OUT, 32'hCAFE_F00D);
        check("R2 out while input", pad_out, 32'hCAFE_F00D);
        check("R2 oe off", pad_oe, 0);
        wr(A_DIR, 32'hFFFF_0000);
        check("R2 oe dir", pad_oe, 32'hFFFF_0000);
        check("R2 out retained", pad_out, 32'hCAFE_F00D);
        wr(A_MODE, 32'h0F00_0000);
        check("R2 oe mode blocks", pad_oe, 32'hF0FF_0000);
        rd(A_DIR, v); check("R10 dir", v, 32'hFFFF_0000);
        rd(A_MODE, v); check("R10 mode", v, 32'h0F00_0000);
        wr(A_MODE, 0); wr(A_DIR, 0);

        // R3 synchroniser latency
        set_pad(32'h1357_2468);
        @(posedge clk);
        rd(A_IN, v); check("R3 one edge old", v, 0);
        @(posedge clk);
        rd(A_IN, v); check("R3 two edges new", v, 32'h1357_2468);

        // R9 general-mode pins never pend
        wr(A_POL, 32'hFFFF_FFFF); wr(A_SENS, 32'h0000_FFFF);
        set_pad(32'hFFFF_0000); repeat (2) @(posedge clk);
        set_pad(32'h0000_FFFF); repeat (4) @(posedge clk);
        rd(A_PEND, v); check("R9 no pending in general mode", v, 0);

        // R4/R5 sweep: pin i uses polarity i[0], sense type i[1]
        pol_m = 32'hAAAA_AAAA; sens_m = 32'hCCCC_CCCC;
        wr(A_POL, pol_m); wr(A_SENS, sens_m);
        set_pad(0); repeat (4) @(posedge clk);
        wr(A_MODE, 32'hFFFF_FFFF); repeat (4) @(posedge clk);
        lvl_prev = 32'h0 ^ pol_m;
        pend_m   = lvl_prev & ~sens_m;
        rd(A_PEND, v);
        check("R4 initial level", v & ~sens_m, pend_m & ~sens_m);
        check("R5 initial edge", v & sens_m, 0);
        steps[0] = 32'hFFFF_FFFF; steps[1] = 32'h0000_0000;
        steps[2] = 32'h0F0F_0F0F; steps[3] = 32'hF0F0_F0F0;
        steps[4] = 32'h3333_CCCC; steps[5] = 32'hFFFF_0000;
        for (int s = 0; s < 6; s++) begin
            set_pad(steps[s]);
            repeat (4) @(posedge clk);
            lvl    = steps[s] ^ pol_m;
            pend_m = ((pend_m | (lvl & ~lvl_prev)) & sens_m) | (lvl & ~sens_m);
            lvl_prev = lvl;
            rd(A_PEND, v);
            check("R4 level pending", v & ~sens_m, pend_m & ~sens_m);
            check("R5 edge pending", v & sens_m, pend_m & sens_m);
        end
        check("R8 masked no irq", {31'b0, irq}, 0);

        // R6 clear semantics
        wr(A_CLR, 0); rd(A_PEND, v); check("R6 zero write no effect", v, pend_m);
        wr(A_CLR, 32'h0000_FFFF);
        pend_m = pend_m & ~(32'h0000_FFFF & sens_m);
        rd(A_PEND, v); check("R6 clear lower half", v, pend_m);

        // R7/R8 mask and irq timing, pin 31 (edge, active-low; pending set)
        wr(A_MCLR, 0); rd(A_MSET, v); check("R7 zero unmask no effect", v, 32'hFFFF_FFFF);
        wr(A_MCLR, 32'h8000_0000);
        check("R8 irq not yet", {31'b0, irq}, 0);
        @(posedge clk); #1;
        check("R8 irq after one edge", {31'b0, irq}, {31'b0, pend_m[31]});
        rd(A_MSET, v); check("R7 unmask one pin", v, 32'h7FFF_FFFF);
        wr(A_MSET, 0); rd(A_MSET, v); check("R7 zero mask no effect", v, 32'h7FFF_FFFF);
        wr(A_MSET, 32'h8000_0000);
        @(posedge clk); #1;
        check("R8 irq drops when masked", {31'b0, irq}, 0);
        wr(A_MCLR, 32'h8000_0000);
        wr(A_CLR, 32'h8000_0000);
        @(posedge clk); #1;
        check("R8 irq drops after clear", {31'b0, irq}, 0);

        // R6 lowest-first drain
        wr(A_MODE, 0); wr(A_POL, 0); wr(A_SENS, 32'hFFFF_FFFF);
        set_pad(0); repeat (4) @(posedge clk);
        wr(A_MODE, 32'h0010_0208);
        set_pad(32'h0010_0208); repeat (4) @(posedge clk);
        begin
            int n = 0;
            int expect_bit [3] = '{3, 9, 20};
            for (int k = 0; k < 40; k++) begin
                int low = -1;
                rd(A_PEND, v);
                if (v == 0) break;
                for (int b = 31; b >= 0; b--) if (v[b]) low = b;
                if (n < 3) check("R6 drain order", low, expect_bit[n]);
                wr(A_CLR, 32'h1 << low);
                n++;
            end
            check("R6 drain count", n, 3);
            rd(A_PEND, v); check("R6 drained", v, 0);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule